// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog timer driven by its own clock. Software controls it through a five-entry register map on a simple write strobe and address bus. The map holds a command entry that accepts 16-bit key codes, a clock-divider select, a 12-bit reload value, a status word and a window value. The window value is only stored and read back; it has no function.

Software opens the divider, reload and window entries for writing with one key code and closes them with any other code. It starts the timer with a second code and refreshes it with a third. After a start, a prescaler divides the clock, and each divided tick decrements a down-counter. If software does not refresh in time, the counter runs out, and the block issues a one-cycle reset request and reloads itself. No key code can stop a running timer; only a system reset returns it to idle.

A written divider or reload value does not take effect at once. It reaches the counting logic after a fixed hand-over delay. While that delay runs, the matching status bit stays set.

Top module: `wdog_keyed_timer`

## Requirements
- R1: After reset, rst_req is 0, status (offset 0x0C) reads 0, the divider select (0x04) reads 0, the reload value (0x08) reads 0xFFF and the window value (0x10) reads 0xFFF.
- R2: Writes to offsets 0x04, 0x08 and 0x10 are accepted only when the most recent command write (offset 0x00) was 0x5555; otherwise they leave the stored value unchanged. After reset these entries are closed.
- R3: Any command write other than 0x5555 closes the configuration entries again, including 0x0000, 0xCCCC, 0xAAAA and undefined codes.
- R4: An accepted write sets status bit 0 (divider) or bit 1 (reload) from the next cycle. The bit stays set for SYNC_DLY cycles and then clears.
- R5: After command 0xAAAA (refresh), or 0xCCCC (start) while idle, rst_req pulses high for exactly one cycle. The pulse comes (reload+1) x divisor clock cycles after the write edge, using the applied values.
- R6: After an expiry the counter reloads by itself, and the next pulse follows one full period later.
- R7: Once started, the timer keeps running whatever command codes follow. 0x0000 and undefined codes neither stop it nor refresh it.
- R8: Before a start, rst_req stays 0, even after refresh commands.
- R9: A refresh before expiry restarts the full period from the refresh.
- R10: The divider select is 3 bits wide. Codes 0 to 6 divide by 4, 8, 16, 32, 64, 128 and 256, and code 7 also divides by 256.
- R11: A new divider or reload value is used only after its status bit clears. A refresh made while the bit is still set loads the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog and bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The assertions assume that bus_wr, bus_addr and bus_wdata are never unknown once reset is released, and that each write strobe lasts a single cycle. The bench drives every bus input from tasks on the falling clock edge. It holds the strobe low between writes and keeps the address on a defined offset at all times. The single-cycle pulse property also depends on the smallest divisor being at least two, which the divider encoding guarantees.

// File: rtl/wdog_pkg.sv
// Package: shared offsets, key codes and divider decode for the keyed watchdog.
// Assumes byte offsets on a 5-bit address and 16-bit data.
package wdog_pkg;
    localparam int BUS_W = 16;
    localparam int ADR_W = 5;
    localparam int SEL_W = 3;
    localparam int DIV_W = 8;

    localparam logic [ADR_W-1:0] OFS_CMD = 5'h00;
    localparam logic [ADR_W-1:0] OFS_DIV = 5'h04;
    localparam logic [ADR_W-1:0] OFS_RLD = 5'h08;
    localparam logic [ADR_W-1:0] OFS_STS = 5'h0C;
    localparam logic [ADR_W-1:0] OFS_WIN = 5'h10;

    localparam logic [BUS_W-1:0] CODE_OPEN  = 16'h5555;
    localparam logic [BUS_W-1:0] CODE_START = 16'hCCCC;
    localparam logic [BUS_W-1:0] CODE_FEED  = 16'hAAAA;

    // Last value of the divided-tick counter for a select code (divisor - 1).
    function automatic logic [DIV_W-1:0] div_last(input logic [SEL_W-1:0] sel);
        logic [DIV_W:0] d;
        d = (sel > 3'd6) ? 9'd256 : (9'd4 << sel);
        return DIV_W'(d - 9'd1);
    endfunction
endpackage

// File: rtl/wdog_key_ctrl.sv
// Key decoder: tracks the open/closed state of the configuration entries and
// the sticky running state, and produces the counter load pulse.
// Assumes cmd_wr is a single-cycle strobe qualified with the command offset.
module wdog_key_ctrl
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [BUS_W-1:0] cmd_val,
    output logic             unlocked,
    output logic             running,
    output logic             load
);
    logic start_hit;
    logic feed_hit;

    // Decode the two codes that touch the counter.
    always_comb begin
        start_hit = cmd_wr && (cmd_val == CODE_START);
        feed_hit  = cmd_wr && (cmd_val == CODE_FEED);
        load      = feed_hit || (start_hit && !running);
    end

    // Any command write re-evaluates the lock; start is sticky until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
            running  <= 1'b0;
        end else begin
            if (cmd_wr) unlocked <= (cmd_val == CODE_OPEN);
            if (start_hit) running <= 1'b1;
        end
    end
endmodule

// File: rtl/wdog_cfg_hold.sv
// Configuration field with a delayed hand-over: the written value is visible
// at once on the bus side and reaches the counting side DLY cycles later,
// with a pending flag in between. A new write restarts the delay.
// Assumes DLY >= 1.
module wdog_cfg_hold #(
    parameter int             W   = 12,
    parameter logic [W-1:0]   RST = '1,
    parameter int             DLY = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_ok,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] shadow,
    output logic [W-1:0] active,
    output logic         pending
);
    localparam int CW = $clog2(DLY + 1);
    localparam logic [CW-1:0] DLY_V = CW'(DLY);

    logic [CW-1:0] dly_cnt;

    // Capture writes, then count down the hand-over delay and apply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow  <= RST;
            active  <= RST;
            pending <= 1'b0;
            dly_cnt <= '0;
        end else if (wr_ok) begin
            shadow  <= wdata;
            pending <= 1'b1;
            dly_cnt <= DLY_V;
        end else if (pending) begin
            if (dly_cnt == CW'(1)) begin
                active  <= shadow;
                pending <= 1'b0;
            end
            dly_cnt <= dly_cnt - CW'(1);
        end
    end
endmodule

// File: rtl/wdog_countdown.sv
// Prescaler plus down-counter. Counts divided ticks while running; on the
// tick that finds the counter at zero it issues a one-cycle request and
// reloads. A load pulse restarts both stages.
// Assumes div_last >= 1 so that requests are never back to back.
module wdog_countdown
    import wdog_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             load,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [DIV_W-1:0] div_last,
    output logic             rst_req
);
    logic [DIV_W-1:0] div_cnt;
    logic [CNT_W-1:0] cnt;
    logic             tick;

    // Divided tick; >= guards against a divider shrunk under a running count.
    always_comb tick = running && (div_cnt >= div_last);

    // Prescaler and down-counter update with expiry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            cnt     <= '1;
            rst_req <= 1'b0;
        end else begin
            rst_req <= 1'b0;
            if (load) begin
                div_cnt <= '0;
                cnt     <= reload_val;
            end else if (tick) begin
                div_cnt <= '0;
                if (cnt == '0) begin
                    cnt     <= reload_val;
                    rst_req <= 1'b1;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
            end else if (running) begin
                div_cnt <= div_cnt + DIV_W'(1);
            end
        end
    end
endmodule

// File: rtl/wdog_keyed_timer.sv
// Top: register map decode and read-back for the keyed watchdog; ties the key
// decoder, the two delayed configuration fields and the countdown together.
// Assumes single-cycle write strobes; reads are combinational on bus_addr.
module wdog_keyed_timer
    import wdog_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int SYNC_DLY = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [ADR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             rst_req
);
    logic             cmd_wr, div_wr, rld_wr, win_wr;
    logic             unlocked, running, load;
    logic [SEL_W-1:0] div_shadow, div_active;
    logic [CNT_W-1:0] rld_shadow, rld_active;
    logic [CNT_W-1:0] win_q;
    logic             pend_div, pend_rld;

    // Address decode; configuration writes qualified by the lock.
    always_comb begin
        cmd_wr = bus_wr && (bus_addr == OFS_CMD);
        div_wr = bus_wr && (bus_addr == OFS_DIV) && unlocked;
        rld_wr = bus_wr && (bus_addr == OFS_RLD) && unlocked;
        win_wr = bus_wr && (bus_addr == OFS_WIN) && unlocked;
    end

    wdog_key_ctrl u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_val  (bus_wdata),
        .unlocked (unlocked),
        .running  (running),
        .load     (load)
    );

    wdog_cfg_hold #(.W(SEL_W), .RST('0), .DLY(SYNC_DLY)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ok   (div_wr),
        .wdata   (bus_wdata[SEL_W-1:0]),
        .shadow  (div_shadow),
        .active  (div_active),
        .pending (pend_div)
    );

    wdog_cfg_hold #(.W(CNT_W), .RST('1), .DLY(SYNC_DLY)) u_rld (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ok   (rld_wr),
        .wdata   (bus_wdata[CNT_W-1:0]),
        .shadow  (rld_shadow),
        .active  (rld_active),
        .pending (pend_rld)
    );

    // Window value: stored under the same lock, no timing function.
    always_ff @(posedge clk) begin
        if (!rst_n)      win_q <= '1;
        else if (win_wr) win_q <= bus_wdata[CNT_W-1:0];
    end

    wdog_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .running    (running),
        .load       (load),
        .reload_val (rld_active),
        .div_last   (div_last(div_active)),
        .rst_req    (rst_req)
    );

    // Read-back mux; the command entry reads as zero.
    always_comb begin
        case (bus_addr)
            OFS_DIV: bus_rdata = BUS_W'(div_shadow);
            OFS_RLD: bus_rdata = BUS_W'(rld_shadow);
            OFS_STS: bus_rdata = BUS_W'({pend_rld, pend_div});
            OFS_WIN: bus_rdata = BUS_W'(win_q);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_keyed_timer_chk.sv
// Checker for wdog_keyed_timer: lock, start stickiness, status and pulse rules.
// Assumes bus inputs are known after reset release.
module wdog_keyed_timer_chk
    import wdog_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [ADR_W-1:0] bus_addr,
    input logic [BUS_W-1:0] bus_wdata,
    input logic             unlocked,
    input logic             running,
    input logic             pend_div,
    input logic             pend_rld,
    input logic [SEL_W-1:0] div_shadow,
    input logic             rst_req
);
    // R2: a closed divider entry holds its value across a write.
    a_r2_closed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DIV && !unlocked) |=> $stable(div_shadow));

    // R3: any non-open command write leaves the entries closed.
    a_r3_relock: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CMD && bus_wdata != CODE_OPEN) |=> !unlocked);

    // R4: a status bit only rises after an accepted write to its entry.
    a_r4_div_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_div) |-> $past(bus_wr && bus_addr == OFS_DIV && unlocked));
    a_r4_rld_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_rld) |-> $past(bus_wr && bus_addr == OFS_RLD && unlocked));

    // R5: the reset request lasts one cycle.
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R7: the running state never drops without reset.
    a_r7_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);

    // R8: no request while idle.
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !rst_req);
endmodule

bind wdog_keyed_timer wdog_keyed_timer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .unlocked   (unlocked),
    .running    (running),
    .pend_div   (pend_div),
    .pend_rld   (pend_rld),
    .div_shadow (div_shadow),
    .rst_req    (rst_req)
);

// File: tb/test_wdog_keyed_timer.sv
// Directed bench for wdog_keyed_timer: one task per scenario.
module test_wdog_keyed_timer;
    localparam int CLK_PERIOD = 10;
    localparam int DLY = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = 5'h00;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        rst_req;
    int          n_chk = 0;
    int          n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_keyed_timer #(.CNT_W(12), .SYNC_DLY(DLY)) i_wdog_keyed_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 5'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Write registers at the next rising edge; returns on the falling edge after it.
    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 5'h00;
    endtask

    // Combinational read without advancing the clock.
    task automatic peek(input logic [4:0] a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = 5'h00;
    endtask

    // Open, set divider and reload, wait until both are applied.
    task automatic setup(input logic [2:0] sel, input logic [11:0] rld);
        wr(5'h00, 16'h5555);
        wr(5'h04, {13'h0, sel});
        wr(5'h08, {4'h0, rld});
        repeat (DLY + 1) @(negedge clk);
    endtask

    // Watch rst_req from edge k0 after the last write edge; expect pulses at t1 and t1+t2.
    task automatic watch(input string req, input int t1, input int t2, input int k0);
        int p1 = -1, p2 = -1, cnt = 0;
        for (int k = k0; k <= t1 + t2 + 1; k++) begin
            @(negedge clk);
            if (rst_req === 1'b1) begin
                cnt++;
                if (p1 < 0) p1 = k; else if (p2 < 0) p2 = k;
            end
        end
        chk({req, " first pulse"}, p1, t1);
        chk({req, " second pulse"}, p2, t1 + t2);
        chk({req, " pulse count"}, cnt, 2);
    endtask

    task automatic t_reset_state();
        logic [15:0] d;
        do_reset();
        chk("R1 rst_req", rst_req, 0);
        peek(5'h0C, d); chk("R1 status", d, 0);
        peek(5'h04, d); chk("R1 divider", d, 0);
        peek(5'h08, d); chk("R1 reload", d, 16'hFFF);
        peek(5'h10, d); chk("R1 window", d, 16'hFFF);
    endtask

    task automatic t_lock();
        logic [15:0] d;
        do_reset();
        wr(5'h04, 16'h0005); peek(5'h04, d); chk("R2 closed divider write", d, 0);
        wr(5'h08, 16'h0123); peek(5'h08, d); chk("R2 closed reload write", d, 16'hFFF);
        peek(5'h0C, d); chk("R2 no status on closed write", d, 0);
        wr(5'h00, 16'h5555);
        wr(5'h04, 16'h0002); peek(5'h04, d); chk("R2 open divider write", d, 2);
        wr(5'h10, 16'h0456); peek(5'h10, d); chk("R2 open window write", d, 16'h456);
    endtask

    task automatic t_relock();
        logic [15:0] d;
        do_reset();
        wr(5'h00, 16'h5555); wr(5'h00, 16'h1234);
        wr(5'h04, 16'h0005); peek(5'h04, d); chk("R3 undefined code relocks", d, 0);
        wr(5'h00, 16'h5555); wr(5'h00, 16'h0000);
        wr(5'h08, 16'h0077); peek(5'h08, d); chk("R3 0x0000 relocks", d, 16'hFFF);
        wr(5'h00, 16'h5555); wr(5'h00, 16'hAAAA);
        wr(5'h10, 16'h0011); peek(5'h10, d); chk("R3 refresh code relocks", d, 16'hFFF);
        wr(5'h00, 16'h5555); wr(5'h00, 16'hCCCC);
        wr(5'h10, 16'h0022); peek(5'h10, d); chk("R3 start code relocks", d, 16'hFFF);
    endtask

    task automatic t_status();
        logic [15:0] d;
        do_reset();
        wr(5'h00, 16'h5555);
        wr(5'h04, 16'h0003);
        peek(5'h0C, d); chk("R4 divider flag set", d, 1);
        repeat (DLY - 1) @(negedge clk);
        peek(5'h0C, d); chk("R4 divider flag held", d, 1);
        @(negedge clk);
        peek(5'h0C, d); chk("R4 divider flag cleared", d, 0);
        wr(5'h08, 16'h0100);
        peek(5'h0C, d); chk("R4 reload flag set", d, 2);
        repeat (DLY - 1) @(negedge clk);
        peek(5'h0C, d); chk("R4 reload flag held", d, 2);
        @(negedge clk);
        peek(5'h0C, d); chk("R4 reload flag cleared", d, 0);
    endtask

    task automatic t_idle();
        int seen = 0;
        do_reset();
        setup(3'd0, 12'd0);
        wr(5'h00, 16'hAAAA);
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (rst_req === 1'b1) seen++;
        end
        chk("R8 no request before start", seen, 0);
    endtask

    task automatic t_start_period();
        do_reset();
        setup(3'd0, 12'd3);
        wr(5'h00, 16'hCCCC);
        watch("R5 R6 start div4 reload3", 16, 16, 1);
        do_reset();
        setup(3'd1, 12'd5);
        wr(5'h00, 16'hCCCC);
        wr(5'h00, 16'hAAAA);
        watch("R5 R6 refresh div8 reload5", 48, 48, 1);
    endtask

    task automatic t_no_stop();
        do_reset();
        setup(3'd0, 12'd3);
        wr(5'h00, 16'hCCCC);
        wr(5'h00, 16'h0000);
        wr(5'h00, 16'hAAAA);
        wr(5'h00, 16'h1234);
        watch("R7 keys neither stop nor refresh", 16, 16, 3);
    endtask

    task automatic t_feed_postpone();
        int seen = 0;
        do_reset();
        setup(3'd0, 12'd3);
        wr(5'h00, 16'hCCCC);
        wr(5'h00, 16'hAAAA);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (rst_req === 1'b1) seen++;
        end
        wr(5'h00, 16'hAAAA);
        chk("R9 no request before refresh", seen, 0);
        watch("R9 period restarts at refresh", 16, 16, 1);
    endtask

    task automatic t_divider_codes();
        do_reset();
        setup(3'd7, 12'd0);
        wr(5'h00, 16'hCCCC);
        watch("R10 code 7 divides by 256", 256, 256, 1);
        do_reset();
        setup(3'd6, 12'd1);
        wr(5'h00, 16'hCCCC);
        watch("R10 code 6 divides by 256", 512, 512, 1);
        do_reset();
        setup(3'd2, 12'd2);
        wr(5'h00, 16'hCCCC);
        watch("R10 code 2 divides by 16", 48, 48, 1);
    endtask

    task automatic t_late_apply();
        logic [15:0] d;
        do_reset();
        setup(3'd0, 12'd3);
        wr(5'h00, 16'hCCCC);
        wr(5'h00, 16'h5555);
        wr(5'h08, 16'h0007);
        wr(5'h00, 16'hAAAA);
        watch("R11 refresh during pending uses old reload", 16, 32, 1);
        peek(5'h0C, d); chk("R11 flag clear after apply", d, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog all requirements actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_lock();
        t_relock();
        t_status();
        t_idle();
        t_start_period();
        t_no_stop();
        t_feed_postpone();
        t_divider_codes();
        t_late_apply();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule